// File: doc/BRIEF.md
# Dual-Subbank Multibank Shared Buffer with Crossbar

This block is an on-chip shared buffer for a group of reconfigurable processors. Its storage is split into several physical banks, and each bank is split again into two halves (subbanks) that work on their own. One side of the block offers one request port per processor's data prefetch unit. These ports reach every subbank through a crossbar. The other side offers one port that stands for the shared system bus toward external memory. All ports use a plain valid/ready handshake. A request is taken in the cycle where its ready is high.

Every subbank does one access per cycle. Requests that target different subbanks are all served together. This holds for a read in one half of a bank and a write in the other half, and also for two reads or two writes in the two halves. When several ports want the same subbank in one cycle, a round-robin arbiter for that subbank picks one. The others see ready low and hold their request. Read data comes back on the requester's own return lane one cycle after the grant. It carries a tag with the requester's index.

Top module: `mbx_buffer`

## Requirements
- R1: A word address is 11 bits. Bits [7:0] pick the word inside a subbank, bit [8] picks the half of the bank, and bits [10:9] pick the bank. Together these give 8 subbanks of 256 words of 64 bits. A word written at an address is returned by a later read of that address.
- R2: A valid request whose subbank no other valid request targets in the same cycle gets ready high in that same cycle. Ready is never high without valid.
- R3: A read in one half of a bank and a write in the other half of the same bank are both granted in the same cycle.
- R4: Two reads, or two writes, that target the two halves of one bank are both granted in the same cycle.
- R5: When several requests target one subbank in a cycle, exactly one of them gets ready. A stalled write has no effect until it is granted, so the word ends up holding the data of the last write granted.
- R6: Requesters are numbered 0 to 3 for the prefetch ports and 4 for the bus port. Each subbank has its own rotating pointer, reset to 0. Among the competing requesters, the first one at or after the pointer (counting upward and wrapping) wins. After a grant to requester g, the pointer moves to g+1 modulo 5.
- R7: A read granted in cycle t raises that requester's return-valid in cycle t+1 only, with the read word and a tag equal to the requester number. At all other times return-valid and the tag are 0.
- R8: The bus port can reach every subbank the same way the prefetch ports can, and it takes part in the same arbitration as requester 4.
- R9: While reset is active, every ready output is low. After reset, every return-valid output is low until a read is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 4 | Request valid, one bit per prefetch port |
| pf_we | input | 4 | Write (1) or read (0), per prefetch port |
| pf_addr | input | 44 | 11-bit word address per prefetch port, port p at [p*11 +: 11] |
| pf_wdata | input | 256 | 64-bit write data per prefetch port |
| pf_ready | output | 4 | Request taken this cycle, per prefetch port |
| pf_rvalid | output | 4 | Read data valid, per prefetch port |
| pf_rdata | output | 256 | 64-bit read data per prefetch port |
| pf_rtag | output | 12 | 3-bit requester tag per prefetch port |
| bus_valid | input | 1 | Bus-side request valid |
| bus_we | input | 1 | Bus-side write (1) or read (0) |
| bus_addr | input | 11 | Bus-side word address |
| bus_wdata | input | 64 | Bus-side write data |
| bus_ready | output | 1 | Bus-side request taken |
| bus_rvalid | output | 1 | Bus-side read data valid |
| bus_rdata | output | 64 | Bus-side read data |
| bus_rtag | output | 3 | Bus-side tag (always 4 when valid) |

## Verification
The first pattern is a full sweep. Every one of the 2048 addresses is written and then read by a single requester, with the requester rotating, so each word carries its own data. This catches any slip in the bank, half or word fields and any crossbar lane that goes to the wrong place. The next pattern fires parallel requests at different subbanks, at the two halves of one bank (read with write, read with read, write with write) and at a single subbank from all five requesters. These separate true per-subbank concurrency from per-bank locking and show the rotating grant order. A five-way write collision on a single word, followed by a read, checks that stalled writes do not land early.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // subbank index carried above the word-offset field
  function automatic int unsigned sub_of(int unsigned addr, int unsigned waw);
    return addr >> waw;
  endfunction

  // distance of requester idx from the priority pointer, wrapping at n
  function automatic int unsigned rr_dist(int unsigned idx, int unsigned ptr, int unsigned n);
    return (idx >= ptr) ? (idx - ptr) : (idx + n - ptr);
  endfunction

  // pointer position following a grant to requester g
  function automatic int unsigned rr_next(int unsigned g, int unsigned n);
    return (g + 1 >= n) ? 0 : g + 1;
  endfunction

endpackage

// File: rtl/mbx_rr_arb.sv
module mbx_rr_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  import mbx_pkg::*;

  logic [IW-1:0] ptr;
  int unsigned   best_d;

  always_comb begin
    gnt_idx = '0;
    best_d  = N;
    for (int i = 0; i < N; i++) begin
      if (req[i] && rr_dist(unsigned'(i), int'(ptr), N) < best_d) begin
        best_d  = rr_dist(unsigned'(i), int'(ptr), N);
        gnt_idx = IW'(i);
      end
    end
    gnt_any = (best_d < N);
    gnt     = '0;
    if (gnt_any) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (gnt_any) ptr <= IW'(rr_next(int'(gnt_idx), N));
  end

endmodule

// File: rtl/mbx_subbank.sv
module mbx_subbank #(
  parameter int DEPTH = 256,
  parameter int DW    = 64,
  localparam int WAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           en,
  input  logic           we,
  input  logic [WAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we)  mem[addr] <= wdata;
    if (en && !we) rdata     <= mem[addr];
  end

endmodule

// File: rtl/mbx_buffer.sv
module mbx_buffer #(
  parameter int NPORT = 4,
  parameter int NBANK = 4,
  parameter int DEPTH = 256,
  parameter int DW    = 64,
  localparam int NREQ = NPORT + 1,
  localparam int NSUB = 2 * NBANK,
  localparam int WAW  = $clog2(DEPTH),
  localparam int SW   = $clog2(NSUB),
  localparam int AW   = WAW + SW,
  localparam int RW   = $clog2(NREQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    pf_valid,
  input  logic [NPORT-1:0]    pf_we,
  input  logic [NPORT*AW-1:0] pf_addr,
  input  logic [NPORT*DW-1:0] pf_wdata,
  output logic [NPORT-1:0]    pf_ready,
  output logic [NPORT-1:0]    pf_rvalid,
  output logic [NPORT*DW-1:0] pf_rdata,
  output logic [NPORT*RW-1:0] pf_rtag,
  input  logic                bus_valid,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                bus_ready,
  output logic                bus_rvalid,
  output logic [DW-1:0]       bus_rdata,
  output logic [RW-1:0]       bus_rtag
);
  import mbx_pkg::*;

  // unified requester view: 0..NPORT-1 prefetch, NPORT = bus
  logic [NREQ-1:0]      r_valid, r_we, r_ready;
  logic [AW-1:0]        r_addr  [NREQ];
  logic [DW-1:0]        r_wdata [NREQ];
  logic [SW-1:0]        r_sub   [NREQ];
  logic [NREQ*SW-1:0]   r_sub_flat;

  // per-subbank crossbar state
  logic [NREQ-1:0]      hit  [NSUB];
  logic [NREQ-1:0]      gnt  [NSUB];
  logic [RW-1:0]        gidx [NSUB];
  logic [NSUB-1:0]      gany;
  logic [DW-1:0]        sb_q [NSUB];
  logic [NSUB*NREQ-1:0] gnt_flat;

  // return path
  logic [NREQ-1:0]      rd_pend;
  logic [SW-1:0]        rd_sub [NREQ];

  for (genvar p = 0; p < NPORT; p++) begin : g_pf_in
    assign r_valid[p] = pf_valid[p] & rst_n;
    assign r_we[p]    = pf_we[p];
    assign r_addr[p]  = pf_addr[p*AW +: AW];
    assign r_wdata[p] = pf_wdata[p*DW +: DW];
  end
  assign r_valid[NPORT] = bus_valid & rst_n;
  assign r_we[NPORT]    = bus_we;
  assign r_addr[NPORT]  = bus_addr;
  assign r_wdata[NPORT] = bus_wdata;

  for (genvar r = 0; r < NREQ; r++) begin : g_sub
    assign r_sub[r]                = SW'(sub_of(int'(r_addr[r]), WAW));
    assign r_sub_flat[r*SW +: SW]  = r_sub[r];
  end

  always_comb begin
    for (int s = 0; s < NSUB; s++)
      for (int r = 0; r < NREQ; r++)
        hit[s][r] = r_valid[r] && (r_sub[r] == SW'(s));
  end

  for (genvar s = 0; s < NSUB; s++) begin : g_sb
    mbx_rr_arb #(.N(NREQ)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (hit[s]),
      .gnt     (gnt[s]),
      .gnt_idx (gidx[s]),
      .gnt_any (gany[s])
    );

    mbx_subbank #(.DEPTH(DEPTH), .DW(DW)) u_mem (
      .clk   (clk),
      .en    (gany[s]),
      .we    (r_we[gidx[s]]),
      .addr  (r_addr[gidx[s]][WAW-1:0]),
      .wdata (r_wdata[gidx[s]]),
      .rdata (sb_q[s])
    );
  end

  always_comb begin
    r_ready  = '0;
    gnt_flat = '0;
    for (int s = 0; s < NSUB; s++) begin
      r_ready                    = r_ready | gnt[s];
      gnt_flat[s*NREQ +: NREQ]   = gnt[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= '0;
      for (int r = 0; r < NREQ; r++) rd_sub[r] <= '0;
    end else begin
      rd_pend <= r_ready & ~r_we;
      for (int r = 0; r < NREQ; r++)
        if (r_ready[r]) rd_sub[r] <= r_sub[r];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_pf_out
    assign pf_ready[p]           = r_ready[p];
    assign pf_rvalid[p]          = rd_pend[p];
    assign pf_rdata[p*DW +: DW]  = sb_q[rd_sub[p]];
    assign pf_rtag[p*RW +: RW]   = rd_pend[p] ? RW'(p) : '0;
  end
  assign bus_ready  = r_ready[NPORT];
  assign bus_rvalid = rd_pend[NPORT];
  assign bus_rdata  = sb_q[rd_sub[NPORT]];
  assign bus_rtag   = rd_pend[NPORT] ? RW'(NPORT) : '0;

endmodule

// File: rtl/mbx_buffer_chk.sv
module mbx_buffer_chk #(
  parameter int NREQ = 5,
  parameter int NSUB = 8,
  parameter int SW   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NREQ-1:0]      r_valid,
  input logic [NREQ-1:0]      r_we,
  input logic [NREQ-1:0]      r_ready,
  input logic [NREQ-1:0]      rd_pend,
  input logic [NREQ*SW-1:0]   r_sub_flat,
  input logic [NSUB*NREQ-1:0] gnt_flat
);
  logic [NREQ-1:0] alone;

  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      alone[r] = r_valid[r];
      for (int q = 0; q < NREQ; q++)
        if (q != r && r_valid[q] && r_sub_flat[q*SW +: SW] == r_sub_flat[r*SW +: SW])
          alone[r] = 1'b0;
    end
  end

  for (genvar s = 0; s < NSUB; s++) begin : g_s
    a_r5_one_grant_per_subbank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_flat[s*NREQ +: NREQ]));
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_r
    a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      r_ready[r] |-> r_valid[r]);
    a_r2_lone_request_granted: assert property (@(posedge clk) disable iff (!rst_n)
      alone[r] |-> r_ready[r]);
    a_r7_return_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (r_ready[r] && !r_we[r]) |=> rd_pend[r]);
    a_r7_no_spurious_return: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend[r] |-> $past(r_ready[r] && !r_we[r]));
    for (genvar q = r + 1; q < NREQ; q++) begin : g_q
      a_r5_collision_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid[r] && r_valid[q] && r_sub_flat[r*SW +: SW] == r_sub_flat[q*SW +: SW])
          |-> !(r_ready[r] && r_ready[q]));
    end
  end

endmodule

bind mbx_buffer mbx_buffer_chk #(.NREQ(NREQ), .NSUB(NSUB), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .r_valid    (r_valid),
  .r_we       (r_we),
  .r_ready    (r_ready),
  .rd_pend    (rd_pend),
  .r_sub_flat (r_sub_flat),
  .gnt_flat   (gnt_flat)
);

// File: tb/mbx_buffer_bench.sv
module mbx_buffer_bench;
  localparam int NPORT = 4;
  localparam int NREQ  = 5;
  localparam int NSUB  = 8;
  localparam int AW    = 11;
  localparam int DW    = 64;
  localparam int RW    = 3;
  localparam int NWORD = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NPORT-1:0]    pf_valid, pf_we, pf_ready, pf_rvalid;
  logic [NPORT*AW-1:0] pf_addr;
  logic [NPORT*DW-1:0] pf_wdata, pf_rdata;
  logic [NPORT*RW-1:0] pf_rtag;
  logic                bus_valid, bus_we, bus_ready, bus_rvalid;
  logic [AW-1:0]       bus_addr;
  logic [DW-1:0]       bus_wdata, bus_rdata;
  logic [RW-1:0]       bus_rtag;

  logic [NREQ-1:0] b_v = '0;
  logic [NREQ-1:0] b_we = '0;
  logic [AW-1:0]   b_a [NREQ];
  logic [DW-1:0]   b_d [NREQ];

  logic [DW-1:0] shadow [NWORD];
  int ptr [NSUB];
  int total = 0;
  int bad = 0;

  always_comb begin
    for (int r = 0; r < NPORT; r++) begin
      pf_valid[r]            = b_v[r];
      pf_we[r]               = b_we[r];
      pf_addr[r*AW +: AW]    = b_a[r];
      pf_wdata[r*DW +: DW]   = b_d[r];
    end
    bus_valid = b_v[NPORT];
    bus_we    = b_we[NPORT];
    bus_addr  = b_a[NPORT];
    bus_wdata = b_d[NPORT];
  end

  mbx_buffer u_mbx_buffer (
    .clk(clk), .rst_n(rst_n),
    .pf_valid(pf_valid), .pf_we(pf_we), .pf_addr(pf_addr), .pf_wdata(pf_wdata),
    .pf_ready(pf_ready), .pf_rvalid(pf_rvalid), .pf_rdata(pf_rdata), .pf_rtag(pf_rtag),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rtag(bus_rtag)
  );

  function automatic logic get_ready(int r);
    return (r < NPORT) ? pf_ready[r] : bus_ready;
  endfunction
  function automatic logic get_rvalid(int r);
    return (r < NPORT) ? pf_rvalid[r] : bus_rvalid;
  endfunction
  function automatic logic [DW-1:0] get_rdata(int r);
    return (r < NPORT) ? pf_rdata[r*DW +: DW] : bus_rdata;
  endfunction
  function automatic logic [RW-1:0] get_rtag(int r);
    return (r < NPORT) ? pf_rtag[r*RW +: RW] : bus_rtag;
  endfunction

  function automatic logic [DW-1:0] pat(int a, int salt);
    return 64'hC3A5_1E0F_0000_0000 ^ (64'(a) * 64'h0001_0003_0007_000F) ^ (64'(salt) << 44);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // runs the requests loaded in b_* until each one has been taken
  task automatic run_burst(string req);
    bit pend [NREQ];
    bit eg [NREQ];
    bit exp_rd [NREQ];
    logic [DW-1:0] exp_dat [NREQ];
    bit any;
    int guard;
    for (int r = 0; r < NREQ; r++) begin pend[r] = b_v[r]; exp_rd[r] = 0; exp_dat[r] = '0; end
    guard = 0;
    any = 1;
    while (any && guard < 40) begin
      guard++;
      for (int r = 0; r < NREQ; r++) b_v[r] = pend[r];
      #1;
      for (int r = 0; r < NREQ; r++) eg[r] = 0;
      for (int s = 0; s < NSUB; s++) begin
        int best;
        best = -1;
        for (int k = 0; k < NREQ; k++) begin
          int idx;
          idx = (ptr[s] + k) % NREQ;
          if (best < 0 && pend[idx] && (int'(b_a[idx]) >> 8) == s) best = idx;
        end
        if (best >= 0) begin
          eg[best] = 1;
          ptr[s] = (best + 1) % NREQ;
        end
      end
      for (int r = 0; r < NREQ; r++) chk(req, $sformatf("ready[%0d]", r), 64'(get_ready(r)), 64'(eg[r]));
      for (int r = 0; r < NREQ; r++)
        if (eg[r] && !b_we[r]) begin exp_rd[r] = 1; exp_dat[r] = shadow[b_a[r]]; end
      for (int r = 0; r < NREQ; r++)
        if (eg[r] && b_we[r]) shadow[b_a[r]] = b_d[r];
      @(posedge clk);
      @(negedge clk);
      for (int r = 0; r < NREQ; r++) if (eg[r]) pend[r] = 0;
      b_v = '0;
      for (int r = 0; r < NREQ; r++) begin
        chk("R7", $sformatf("rvalid[%0d]", r), 64'(get_rvalid(r)), 64'(exp_rd[r]));
        if (exp_rd[r]) begin
          chk(req, $sformatf("rdata[%0d]", r), get_rdata(r), exp_dat[r]);
          chk("R7", $sformatf("rtag[%0d]", r), 64'(get_rtag(r)), 64'(r));
        end else begin
          chk("R7", $sformatf("rtag idle[%0d]", r), 64'(get_rtag(r)), 64'd0);
        end
        exp_rd[r] = 0;
      end
      any = 0;
      for (int r = 0; r < NREQ; r++) if (pend[r]) any = 1;
    end
    b_v = '0;
  endtask

  task automatic load(int r, bit we, int a, logic [DW-1:0] d);
    b_v[r]  = 1'b1;
    b_we[r] = we;
    b_a[r]  = AW'(a);
    b_d[r]  = d;
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSUB; s++) ptr[s] = 0;
    for (int r = 0; r < NREQ; r++) begin b_a[r] = '0; b_d[r] = '0; end
    for (int a = 0; a < NWORD; a++) shadow[a] = '0;

    // R9: ready held low during reset even with a request present
    @(negedge clk);
    load(0, 1'b0, 5, '0);
    load(NPORT, 1'b1, 300, 64'h1);
    #1;
    chk("R9", "ready[0] in reset", 64'(get_ready(0)), 64'd0);
    chk("R9", "ready[4] in reset", 64'(get_ready(NPORT)), 64'd0);
    b_v = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < NREQ; r++)
      chk("R9", $sformatf("rvalid[%0d] after reset", r), 64'(get_rvalid(r)), 64'd0);

    // R1 / R8: write every address, requester rotating through all five
    for (int a = 0; a < NWORD; a++) begin
      load(a % NREQ, 1'b1, a, pat(a, 1));
      run_burst((a % NREQ == NPORT) ? "R8" : "R1");
    end
    // R1 / R8: read every address back through another requester
    for (int a = 0; a < NWORD; a++) begin
      load((a + 2) % NREQ, 1'b0, a, '0);
      run_burst(((a + 2) % NREQ == NPORT) ? "R8" : "R1");
    end

    // R2: five reads to five different subbanks in one cycle
    for (int r = 0; r < NREQ; r++) load(r, 1'b0, (r << 8) | 7, '0);
    run_burst("R2");

    // R3: read half 0 of bank 1 while writing half 1 of bank 1
    load(0, 1'b0, (2 << 8) | 5, '0);
    load(NPORT, 1'b1, (3 << 8) | 5, pat(99, 3));
    run_burst("R3");
    load(1, 1'b0, (3 << 8) | 5, '0);
    run_burst("R3");

    // R4: two reads to bank 2 halves, two writes to bank 3 halves
    load(1, 1'b0, (4 << 8) | 17, '0);
    load(2, 1'b0, (5 << 8) | 17, '0);
    load(0, 1'b1, (6 << 8) | 33, pat(7, 4));
    load(3, 1'b1, (7 << 8) | 33, pat(8, 4));
    run_burst("R4");
    load(4, 1'b0, (6 << 8) | 33, '0);
    load(2, 1'b0, (7 << 8) | 33, '0);
    run_burst("R4");

    // R5: five writes to one word; stalled writers hold, last winner stays
    for (int r = 0; r < NREQ; r++) load(r, 1'b1, 12'h0AB, pat(r, 9));
    run_burst("R5");
    load(3, 1'b0, 12'h0AB, '0);
    run_burst("R5");

    // R6: five reads to one subbank, then a partial group on another
    for (int r = 0; r < NREQ; r++) load(r, 1'b0, (6 << 8) | (r * 11), '0);
    run_burst("R6");
    load(1, 1'b0, (1 << 8) | 1, '0);
    load(2, 1'b0, (1 << 8) | 2, '0);
    load(4, 1'b0, (1 << 8) | 3, '0);
    run_burst("R6");
    load(0, 1'b1, (1 << 8) | 9, pat(1, 6));
    load(4, 1'b1, (1 << 8) | 9, pat(2, 6));
    run_burst("R6");
    load(2, 1'b0, (1 << 8) | 9, '0);
    run_burst("R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule